// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor. Each cycle it takes an operation code, the accumulator byte, a second operand byte, the incoming carry and a 3-bit bit index. From these it computes an 8-bit result and a candidate value for each of six status flags. Operand fetch, decode and the register file are handled elsewhere.

Each operation has its own rule for the flags. The block drives a per-flag write mask beside the candidate values, so a flag that an operation leaves alone keeps its stored value. The same applies to a flag whose value the operation leaves undefined. A 6-bit flag register inside the block takes the masked update on each cycle with the valid strobe high. A separate strobe tells the register file whether the result byte is meant to be written back to the accumulator.

Top module: `alu8_flags`

## Requirements
- R1: Op code 0 (add) gives result = (acc + opnd) mod 256 and ignores the carry input. C is set on a carry out of bit 7, and H is set on a carry out of bit 3.
- R2: Op code 1 (add with carry) gives result = (acc + opnd + carry_in) mod 256. The carry input is counted when H and C are formed.
- R3: For op codes 0 and 1, P/V is set on two's-complement signed overflow and N is cleared.
- R4: For op codes 0, 1, 2, 3 and 5, S is bit 7 of the result and Z is set when the result is zero.
- R5: Op code 2 (AND) gives result = acc & opnd. It sets H, clears N and C, and sets P/V when the result has an even number of ones.
- R6: Op code 3 (XOR) gives result = acc ^ opnd. It clears H, N and C, and sets P/V when the result has an even number of ones.
- R7: Op code 4 (bit test) sets Z to the inverse of opnd bit bit_sel, sets H and clears N. S, P/V and C keep their prior stored values, and flag_we is 6'b011010.
- R8: Op code 5 (port test) forms acc & opnd and writes all six flags as AND does (H set, N and C cleared, P/V even parity). It does not request an accumulator write.
- R9: result_we is 1 only for op codes 0 to 3. flag_we is 6'h3F for op codes 0, 1, 2, 3 and 5, and 0 for op codes 6 and 7.
- R10: flags_q bit order is {S, Z, H, P/V, N, C} from bit 5 down to bit 0. A synchronous reset clears it. It changes only on a rising clock edge with alu_valid high, and then only in the bits set in flag_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_valid | input | 1 | Strobe that commits the flag update this cycle |
| op | input | 3 | Operation code (0 add, 1 add with carry, 2 AND, 3 XOR, 4 bit test, 5 port test) |
| acc_in | input | 8 | Accumulator operand, or port value for the port test |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry for add with carry |
| bit_sel | input | 3 | Bit index for the bit test |
| result | output | 8 | Combinational result byte |
| result_we | output | 1 | Result is to be written to the accumulator |
| flag_we | output | 6 | Per-flag write mask, same bit order as flags_q |
| flags_q | output | 6 | Registered flags {S, Z, H, P/V, N, C} |

## Verification
The embedded properties check the register's own behaviour on every cycle. They cover holding without a strobe and clearing on reset. They also cover the zero flag tracking the committed result, the fixed H, N and C values for AND and XOR, and C being kept across a bit test. Exact arithmetic values depend on particular operand pairs, so only the directed scenarios can show them. These include half-carry from bit 3, signed overflow at 7F+01 and 80+80, and carry chains through carry_in. The scenarios also show the parity on specific bytes, and that S and P/V survive a bit test with the values an earlier add left.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       alu_valid,
  input  logic [2:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       carry_in,
  input  logic [2:0] bit_sel,
  output logic [7:0] result,
  output logic       result_we,
  output logic [5:0] flag_we,
  output logic [5:0] flags_q
);

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_XOR = 3'd3;
  localparam logic [2:0] OP_BIT = 3'd4;
  localparam logic [2:0] OP_TIO = 3'd5;

  localparam int FS = 5, FZ = 4, FH = 3, FPV = 2, FN = 1, FC = 0;

  logic       cin_eff;
  logic [4:0] low_sum;
  logic [8:0] full_sum;
  logic [7:0] and_val;
  logic       ovf;
  logic [5:0] flag_new;

  assign cin_eff  = (op == OP_ADC) ? carry_in : 1'b0;
  assign low_sum  = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin_eff};
  assign full_sum = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin_eff};
  assign and_val  = acc_in & opnd_in;
  assign ovf      = (acc_in[7] == opnd_in[7]) && (full_sum[7] != acc_in[7]);

  always_comb begin
    result    = 8'h00;
    result_we = 1'b0;
    flag_we   = 6'h00;
    flag_new  = 6'h00;
    case (op)
      OP_ADD, OP_ADC: begin
        result        = full_sum[7:0];
        result_we     = 1'b1;
        flag_we       = 6'h3F;
        flag_new[FS]  = full_sum[7];
        flag_new[FZ]  = (full_sum[7:0] == 8'h00);
        flag_new[FH]  = low_sum[4];
        flag_new[FPV] = ovf;
        flag_new[FC]  = full_sum[8];
      end
      OP_AND, OP_XOR, OP_TIO: begin
        result        = (op == OP_XOR) ? (acc_in ^ opnd_in) : and_val;
        result_we     = (op != OP_TIO);
        flag_we       = 6'h3F;
        flag_new[FS]  = result[7];
        flag_new[FZ]  = (result == 8'h00);
        flag_new[FH]  = (op != OP_XOR);
        flag_new[FPV] = ~^result;
      end
      OP_BIT: begin
        flag_we[FZ]  = 1'b1;
        flag_we[FH]  = 1'b1;
        flag_we[FN]  = 1'b1;
        flag_new[FZ] = ~opnd_in[bit_sel];
        flag_new[FH] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= 6'h00;
    else if (alu_valid)
      flags_q <= (flags_q & ~flag_we) | (flag_new & flag_we);
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> flags_q == 6'h00);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !alu_valid |=> $stable(flags_q));

  assert_zero_tracks_result_R4: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op <= OP_XOR) |=> flags_q[FZ] == ($past(result) == 8'h00));

  assert_and_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op == OP_AND) |=> flags_q[FH] && !flags_q[FN] && !flags_q[FC]);

  assert_xor_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op == OP_XOR) |=> !flags_q[FH] && !flags_q[FN] && !flags_q[FC]);

  assert_bit_keeps_c_R7: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op == OP_BIT) |=> flags_q[FC] == $past(flags_q[FC])
                                     && flags_q[FS] == $past(flags_q[FS])
                                     && flags_q[FZ] == ~$past(opnd_in[bit_sel]));

  assert_write_mask_R9: assert property (@(posedge clk) disable iff (rst)
    result_we |-> flag_we == 6'h3F);

endmodule

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       alu_valid;
  logic [2:0] op;
  logic [7:0] acc_in, opnd_in;
  logic       carry_in;
  logic [2:0] bit_sel;
  logic [7:0] result;
  logic       result_we;
  logic [5:0] flag_we;
  logic [5:0] flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in), .bit_sel(bit_sel),
    .result(result), .result_we(result_we), .flag_we(flag_we), .flags_q(flags_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] o, input logic [7:0] a,
                        input logic [7:0] b, input logic ci, input logic [2:0] bs,
                        input logic v, input int exp_res, input int exp_we,
                        input int exp_fwe, input int exp_flags);
    @(negedge clk);
    op = o; acc_in = a; opnd_in = b; carry_in = ci; bit_sel = bs; alu_valid = v;
    #1;
    if (exp_res >= 0) chk({req, " result"}, result, exp_res);
    chk({req, " result_we"}, result_we, exp_we);
    chk({req, " flag_we"}, flag_we, exp_fwe);
    @(negedge clk);
    alu_valid = 1'b0;
    chk({req, " flags"}, flags_q, exp_flags);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 reset", flags_q, 6'h00);
  endtask

  task automatic t_add();
    run_op("R1 add half", 3'd0, 8'h0F, 8'h01, 1'b1, 3'd0, 1'b1, 8'h10, 1, 6'h3F, 6'h08);
    run_op("R3 add ovf", 3'd0, 8'h7F, 8'h01, 1'b0, 3'd0, 1'b1, 8'h80, 1, 6'h3F, 6'h2C);
    run_op("R1 R4 add wrap", 3'd0, 8'hFF, 8'h01, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h19);
  endtask

  task automatic t_adc();
    run_op("R2 adc plain", 3'd1, 8'h10, 8'h20, 1'b1, 3'd0, 1'b1, 8'h31, 1, 6'h3F, 6'h00);
    run_op("R2 adc half", 3'd1, 8'h0F, 8'h00, 1'b1, 3'd0, 1'b1, 8'h10, 1, 6'h3F, 6'h08);
    run_op("R3 adc negovf", 3'd1, 8'h80, 8'h80, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h15);
  endtask

  task automatic t_logic();
    run_op("R5 and even", 3'd2, 8'hF0, 8'h3C, 1'b1, 3'd0, 1'b1, 8'h30, 1, 6'h3F, 6'h0C);
    run_op("R5 and zero", 3'd2, 8'hAA, 8'h55, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h1C);
    run_op("R5 R4 and odd", 3'd2, 8'h81, 8'h80, 1'b0, 3'd0, 1'b1, 8'h80, 1, 6'h3F, 6'h28);
    run_op("R6 xor odd", 3'd3, 8'hFF, 8'h01, 1'b1, 3'd0, 1'b1, 8'hFE, 1, 6'h3F, 6'h20);
    run_op("R6 xor zero", 3'd3, 8'h55, 8'h55, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h14);
  endtask

  task automatic t_bit();
    run_op("R7 setup", 3'd0, 8'h7F, 8'h01, 1'b0, 3'd0, 1'b1, 8'h80, 1, 6'h3F, 6'h2C);
    run_op("R7 bit keep S PV", 3'd4, 8'h00, 8'hFE, 1'b0, 3'd0, 1'b1, -1, 0, 6'h1A, 6'h3C);
    run_op("R7 setup2", 3'd0, 8'hFF, 8'h01, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h19);
    run_op("R7 bit keep C", 3'd4, 8'h00, 8'h80, 1'b0, 3'd7, 1'b1, -1, 0, 6'h1A, 6'h09);
  endtask

  task automatic t_tio();
    run_op("R8 port test", 3'd5, 8'h0F, 8'h03, 1'b1, 3'd0, 1'b1, 8'h03, 0, 6'h3F, 6'h0C);
  endtask

  task automatic t_hold();
    run_op("R10 setup", 3'd0, 8'hFF, 8'h01, 1'b0, 3'd0, 1'b1, 8'h00, 1, 6'h3F, 6'h19);
    run_op("R10 no strobe", 3'd0, 8'h7F, 8'h01, 1'b0, 3'd0, 1'b0, 8'h80, 1, 6'h3F, 6'h19);
    run_op("R9 reserved", 3'd6, 8'h12, 8'h34, 1'b1, 3'd0, 1'b1, -1, 0, 6'h00, 6'h19);
    t_reset();
  endtask

  initial begin
    rst = 1'b1; alu_valid = 1'b0; op = 3'd0; acc_in = 8'h00;
    opnd_in = 8'h00; carry_in = 1'b0; bit_sel = 3'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 initial", flags_q, 6'h00);
    t_add();
    t_adc();
    t_logic();
    t_bit();
    t_tio();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule